// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, once per cycle, which hardware thread of a multithreaded front end may fetch. Each thread reports a 3-bit status code, and for the occupancy policy a downstream queue count. The block combines these with the selected arbitration policy and returns a valid flag and a thread id. When no thread qualifies, or when a drain request is active, the valid flag is low.

Three policies are available. The fixed policy always picks thread 0. The rotating policy keeps an ordered list of thread ids: the first eligible thread from the head wins, and once the fetch stage consumes that grant (shown by `take_i`), the thread moves to the tail. The occupancy policy picks the eligible thread with the smallest queue count. The policy input is a static setting that the block latches on the first clock edge after reset is released.

Top module: `fetch_thread_sel`

## Requirements
- R1: Only the status codes idle (0), running (1) and access-complete (2) make a thread eligible. Codes 3 to 7 (squashing, blocked, waiting on response, waiting on retry, quiesced) never lead to a grant of that thread.
- R2: When no thread is eligible, `grant_valid_o` is low.
- R3: While `drain_i` is high, `grant_valid_o` is low for every status, count and policy.
- R4: Under the rotating policy (code 1, and also code 3), the grant goes to the first eligible thread in list order, starting from the head.
- R5: Under the rotating policy, a cycle with `take_i` high and a valid grant moves the granted thread to the tail, and the other entries keep their relative order. Without that combination the list is unchanged.
- R6: Reset loads the list in ascending id order, with thread 0 at the head.
- R7: Under the occupancy policy (code 2), the grant goes to the eligible thread with the smallest count in `occ_i` (thread t in bits [t*CNT_W +: CNT_W]). On equal counts the lower id wins.
- R8: Under the fixed policy (code 0), with more than one thread, the grant is thread 0 when thread 0 is eligible. Otherwise there is no grant.
- R9: With NUM_THREADS = 1, thread 0 is granted exactly when it is eligible and no drain is active, whatever the policy code.
- R10: `policy_i` is latched at the first clock edge after reset is released. Later changes have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Policy code: 0 fixed, 1 rotating, 2 occupancy, 3 rotating |
| drain_i | input | 1 | Drain pending; suppresses any grant |
| take_i | input | 1 | Fetch stage consumes the current grant |
| status_i | input | NUM_THREADS*3 | Per-thread status code, thread t in bits [3t +: 3] |
| occ_i | input | NUM_THREADS*CNT_W | Per-thread queue count |
| grant_valid_o | output | 1 | A thread is granted this cycle |
| grant_tid_o | output | TID_W | Granted thread id |

## Verification
The only state in this block is the rotation list and the latched policy. A wrong list entry therefore shows up at the ports on the first cycle where two or more threads are eligible under the rotating policy: the bench's model picks a different id in that same cycle. A list that rotates without a take, or fails to rotate after one, is visible within one cycle once the affected thread competes again. A policy that was latched wrongly or not held changes the chosen id on the first cycle where the policies disagree. Full sweeps over every combination of status codes for four threads, run under every policy code, keep such a cycle close to any fault.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int ST_W = 3;

  typedef enum logic [2:0] {
    TS_IDLE       = 3'd0,
    TS_RUN        = 3'd1,
    TS_ACC_DONE   = 3'd2,
    TS_SQUASH     = 3'd3,
    TS_BLOCK      = 3'd4,
    TS_WAIT_RSP   = 3'd5,
    TS_WAIT_RETRY = 3'd6,
    TS_QUIESCE    = 3'd7
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_FIXED      = 2'd0,
    POL_ROTATE     = 2'd1,
    POL_OCC        = 2'd2,
    POL_ROTATE_ALT = 2'd3
  } fetch_pol_e;
endpackage

// File: rtl/fts_elig.sv
module fts_elig import fts_pkg::*; #(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS*ST_W-1:0] status_i,
  output logic [NUM_THREADS-1:0]      elig_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    thr_state_e st;
    assign st = thr_state_e'(status_i[t*ST_W +: ST_W]);
    assign elig_o[t] = (st == TS_IDLE) || (st == TS_RUN) || (st == TS_ACC_DONE);
  end
endmodule

// File: rtl/fts_rr_list.sv
module fts_rr_list #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] elig_i,
  input  logic                   upd_i,
  output logic                   hit_o,
  output logic [TID_W-1:0]       tid_o
);
  localparam int POS_W = TID_W;

  logic [NUM_THREADS-1:0][TID_W-1:0] order_q, order_d;
  logic [POS_W-1:0]                  pos;

  // first eligible entry from the head wins
  always_comb begin
    hit_o = 1'b0;
    pos   = '0;
    tid_o = '0;
    for (int p = NUM_THREADS - 1; p >= 0; p--) begin
      if (elig_i[order_q[p]]) begin
        hit_o = 1'b1;
        pos   = POS_W'(p);
        tid_o = order_q[p];
      end
    end
  end

  always_comb begin
    order_d = order_q;
    for (int p = 0; p < NUM_THREADS - 1; p++) begin
      if (POS_W'(p) >= pos) order_d[p] = order_q[p+1];
    end
    order_d[NUM_THREADS-1] = tid_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_THREADS; p++) order_q[p] <= TID_W'(p);
    end else if (upd_i && hit_o) begin
      order_q <= order_d;
    end
  end

  logic [NUM_THREADS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int p = 0; p < NUM_THREADS; p++) seen[order_q[p]] = 1'b1;
  end

  AST_LIST_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen == {NUM_THREADS{1'b1}}); // R5
  AST_LIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(order_q)); // R5
  AST_LIST_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && hit_o) |=> order_q[NUM_THREADS-1] == $past(tid_o)); // R5
endmodule

// File: rtl/fts_occ_pick.sv
module fts_occ_pick #(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 6,
  parameter int TID_W       = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_THREADS-1:0]       elig_i,
  input  logic [NUM_THREADS*CNT_W-1:0] occ_i,
  output logic                         hit_o,
  output logic [TID_W-1:0]             tid_o
);
  logic [CNT_W-1:0] best;

  // strict less-than keeps the lower id on ties
  always_comb begin
    hit_o = 1'b0;
    tid_o = '0;
    best  = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (elig_i[t] && (!hit_o || occ_i[t*CNT_W +: CNT_W] < best)) begin
        hit_o = 1'b1;
        tid_o = TID_W'(t);
        best  = occ_i[t*CNT_W +: CNT_W];
      end
    end
  end

  logic min_ok;
  always_comb begin
    min_ok = elig_i[tid_o];
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (elig_i[t]) begin
        if (occ_i[t*CNT_W +: CNT_W] < occ_i[tid_o*CNT_W +: CNT_W]) min_ok = 1'b0;
        if (TID_W'(t) < tid_o &&
            occ_i[t*CNT_W +: CNT_W] == occ_i[tid_o*CNT_W +: CNT_W]) min_ok = 1'b0;
      end
    end
  end

  AST_OCC_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> min_ok); // R7
  AST_OCC_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_i == '0) |-> !hit_o); // R2
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel import fts_pkg::*; #(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 6,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   policy_i,
  input  logic                         drain_i,
  input  logic                         take_i,
  input  logic [NUM_THREADS*ST_W-1:0]  status_i,
  input  logic [NUM_THREADS*CNT_W-1:0] occ_i,
  output logic                         grant_valid_o,
  output logic [TID_W-1:0]             grant_tid_o
);
  fetch_pol_e             policy_q, eff_pol;
  logic                   pol_lat_q;
  logic [NUM_THREADS-1:0] elig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      policy_q  <= POL_FIXED;
      pol_lat_q <= 1'b0;
    end else if (!pol_lat_q) begin
      policy_q  <= fetch_pol_e'(policy_i);
      pol_lat_q <= 1'b1;
    end
  end

  assign eff_pol = pol_lat_q ? policy_q : fetch_pol_e'(policy_i);

  fts_elig #(.NUM_THREADS(NUM_THREADS)) elig_i (
    .status_i (status_i),
    .elig_o   (elig)
  );

  if (NUM_THREADS == 1) begin : g_single
    logic unused_in;
    assign unused_in     = ^{take_i, occ_i, eff_pol};
    assign grant_valid_o = elig[0] && !drain_i;
    assign grant_tid_o   = '0;
  end else begin : g_multi
    logic             rr_hit, occ_hit, rr_upd, sel_hit;
    logic [TID_W-1:0] rr_tid, occ_tid, sel_tid;
    logic             is_rot;

    assign is_rot = (eff_pol == POL_ROTATE) || (eff_pol == POL_ROTATE_ALT);
    assign rr_upd = take_i && grant_valid_o && is_rot;

    fts_rr_list #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) rr_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .elig_i (elig),
      .upd_i  (rr_upd),
      .hit_o  (rr_hit),
      .tid_o  (rr_tid)
    );

    fts_occ_pick #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) occ_pick_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .elig_i (elig),
      .occ_i  (occ_i),
      .hit_o  (occ_hit),
      .tid_o  (occ_tid)
    );

    always_comb begin
      unique case (eff_pol)
        POL_FIXED: begin sel_hit = elig[0]; sel_tid = '0;      end
        POL_OCC:   begin sel_hit = occ_hit; sel_tid = occ_tid; end
        default:   begin sel_hit = rr_hit;  sel_tid = rr_tid;  end
      endcase
    end

    assign grant_valid_o = sel_hit && !drain_i;
    assign grant_tid_o   = sel_tid;
  end

  AST_GRANT_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (status_i[grant_tid_o*ST_W +: ST_W] <= 3'd2)); // R1
  AST_NO_ELIG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig == '0) |-> !grant_valid_o); // R2
  AST_DRAIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i |-> !grant_valid_o); // R3
  AST_POL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pol_lat_q) |-> $stable(policy_q)); // R10
endmodule

// File: tb/fetch_thread_sel_tb_top.sv
module fetch_thread_sel_tb_top;
  localparam int N  = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    policy;
  logic          drain, take;
  logic [N*3-1:0] status;
  logic [N*CW-1:0] occ;
  logic          gv, gv1;
  logic [1:0]    gtid;
  logic [0:0]    gtid1;

  int tests = 0, fails = 0;
  int order[N];
  bit done = 0;

  always #2.5 clk = ~clk;

  fetch_thread_sel #(.NUM_THREADS(N), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .drain_i(drain), .take_i(take),
    .status_i(status), .occ_i(occ), .grant_valid_o(gv), .grant_tid_o(gtid));

  fetch_thread_sel #(.NUM_THREADS(1), .CNT_W(CW)) dut1_i (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .drain_i(drain), .take_i(take),
    .status_i(status[2:0]), .occ_i(occ[CW-1:0]), .grant_valid_o(gv1), .grant_tid_o(gtid1));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit el(input int t);
    int s;
    s = int'(status[t*3 +: 3]);
    return s <= 2;
  endfunction

  task automatic expect_grant(input int pol, output bit v, output int tid);
    v = 0; tid = 0;
    if (pol == 0) begin
      v = el(0); tid = 0;
    end else if (pol == 2) begin
      for (int t = 0; t < N; t++)
        if (el(t) && (!v || occ[t*CW +: CW] < occ[tid*CW +: CW])) begin v = 1; tid = t; end
    end else begin
      for (int p = N - 1; p >= 0; p--)
        if (el(order[p])) begin v = 1; tid = order[p]; end
    end
    if (drain) v = 0;
  endtask

  task automatic rotate(input int tid);
    int pos = 0;
    for (int p = 0; p < N; p++) if (order[p] == tid) pos = p;
    for (int p = pos; p < N - 1; p++) order[p] = order[p+1];
    order[N-1] = tid;
  endtask

  initial begin
    bit v;
    int tid;
    string rq;
    rst_n = 1'b0; drain = 0; take = 0; status = '0; occ = '0; policy = 2'd1;
    for (int pol = 0; pol < 4; pol++) begin
      @(negedge clk);
      rst_n = 1'b0; policy = 2'(pol);
      drain = 0; take = 0; status = {N{3'd1}}; occ = '0;
      for (int p = 0; p < N; p++) order[p] = p;
      #1;
      // R6: list ascending at reset, all threads running
      if (pol == 1 || pol == 3) begin
        chk("R6 reset valid", int'(gv), 1);
        chk("R6 reset head", int'(gtid), 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4096; i++) begin
        status = 12'(i);
        for (int t = 0; t < N; t++)
          occ[t*CW +: CW] = (i % 5 == 0) ? CW'(7) : CW'((i * 3 + t * 11 + (i >> 4)) % 16);
        take  = (i % 3) != 0;
        drain = (i % 17) == 5;
        if (i == 2048) policy = 2'((pol + 1) % 4); // R10: must be ignored
        #1;
        expect_grant(pol, v, tid);
        case (pol)
          0: rq = "R8 fixed";
          2: rq = "R7 occupancy";
          default: rq = "R4 R5 rotate";
        endcase
        if (drain) rq = "R3 drain";
        else if (status[2:0] > 2 && status[5:3] > 2 && status[8:6] > 2 && status[11:9] > 2)
          rq = "R2 none eligible";
        if (i >= 2048) rq = {rq, " R10 policy held"};
        chk({rq, " valid"}, int'(gv), int'(v));
        if (v) begin
          chk({rq, " tid"}, int'(gtid), tid);
          chk("R1 eligible status", int'(status[gtid*3 +: 3] <= 3'd2), 1);
        end
        chk("R9 single thread valid", int'(gv1), int'(el(0) && !drain));
        if (gv1) chk("R9 single thread tid", int'(gtid1), 0);
        if (take && v && (pol == 1 || pol == 3)) rotate(tid);
        @(negedge clk);
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule